// File: doc/BRIEF.md
# Camera Pixel Capture with Ping-Pong Line Banks

This block takes a parallel camera stream on its own pixel clock and moves the usable pixels onto a system-clock write port that feeds a USB-side slave FIFO. The camera side gives a 12-bit pixel word and three strobes: frame, line and data qualifiers. Only pixels that all three strobes qualify enter the block. They cross into the system domain through a small dual-clock FIFO with Gray-coded pointers.

In the system domain, the pixels fill two line banks in turn. Each bank holds up to one full 1024-pixel line. One bank is emptied toward the USB port while the other bank fills, so neither side waits on the other. The first pixel of a frame carries a start marker, and the last pixel of each bank carries an end-of-line marker. Two sticky error flags are provided. The first reports a line lost because both banks were still occupied. The second reports a frame that has more lines than allowed.

Each clock domain has its own synchronous active-low reset. The system clock is expected to run at least as fast as the camera pixel clock.

Top module: `campix_pingpong`

## Requirements
- R1: A pixel is taken on a rising edge of `cam_clk` only when `cam_fval`, `cam_lval` and `cam_dval` are all high at that edge. A pixel presented with any one of the three strobes low never appears at the output.
- R2: Each taken pixel leaves as one 16-bit word on `usb_data`. Bits 11:0 hold the pixel and bits 15:12 are zero. Words leave in the order the pixels arrived.
- R3: Pixels cross from the camera clock to the system clock through a 16-entry FIFO that uses Gray-coded pointers. Each pointer advances by at most one step per clock, and no pixel is lost when the system clock is the faster of the two.
- R4: A bank closes when it holds 1024 pixels. The next pixel of the same line goes into the other bank.
- R5: A bank also closes, holding a partial line, when `cam_lval` falls after at least one taken pixel.
- R6: A line that starts while the bank it would use has not been emptied is dropped whole, and `ovf_flag` is set. The flag stays set until reset. Lines already stored are still delivered, and the lines after the drop are stored normally once a bank is free.
- R7: `usb_sof` is high with the first word of each frame, meaning the first taken pixel after `cam_fval` rises. `usb_eol` is high with the last word of each bank. Neither marker is high without `usb_wr`.
- R8: Lines, counted as rises of `cam_lval` while `cam_fval` is high, are counted per frame. The count clears while `cam_fval` is low. A 1025th line in one frame sets the sticky `line_err`, and a frame of 1024 lines does not.
- R9: `usb_wr` is high only in a cycle where `usb_full` was low at the previous `sys_clk` edge. Holding `usb_full` high stalls the output without losing stored words.
- R10: While `cam_rst_n` and `sys_rst_n` are low, the block clears `usb_wr`, `ovf_flag`, `line_err`, the FIFO pointers and the bank states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cam_clk | input | 1 | Camera pixel clock |
| cam_rst_n | input | 1 | Synchronous active-low reset, camera domain |
| cam_fval | input | 1 | Frame qualifier strobe |
| cam_lval | input | 1 | Line qualifier strobe |
| cam_dval | input | 1 | Data qualifier strobe |
| cam_data | input | 12 | Pixel value |
| line_err | output | 1 | Sticky: too many lines in one frame (camera domain) |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| usb_full | input | 1 | USB-side FIFO cannot take a word |
| usb_wr | output | 1 | Write strobe toward the USB-side FIFO |
| usb_data | output | 16 | Zero-extended pixel word |
| usb_sof | output | 1 | Start-of-frame marker, valid with `usb_wr` |
| usb_eol | output | 1 | End-of-bank marker, valid with `usb_wr` |
| ovf_flag | output | 1 | Sticky: a line was dropped for lack of a free bank |

## Verification
The bench goes after the following corner cases.

- Pixels with one strobe low, placed between lines and outside frames. A design that ignored a strobe would emit extra words.
- A 1030-pixel line that must split at 1024. A design with a wrong split would put the end marker in the wrong place or merge the two banks.
- A third line sent while `usb_full` holds both banks. A design that did not drop the whole line would interleave stray pixels with the stored lines, or would forget the flag.
- Frames of exactly 1024 lines, sent back to back, and then one of 1025 lines. These show whether the line counter clears between frames and whether it trips at the right count.

// File: rtl/campix_pkg.sv
// Package: shared defaults and the per-bank state type for the camera
// capture block. Assumes nothing beyond IEEE 1800-2017.
package campix_pkg;

    localparam int DEF_PIX_W     = 12;
    localparam int DEF_OUT_W     = 16;
    localparam int DEF_LINE_PIX  = 1024;
    localparam int DEF_MAX_LINES = 1024;
    localparam int DEF_FIFO_AW   = 4;

    // State of one line bank as seen by both the writer and the reader.
    typedef enum logic {
        BANK_FREE  = 1'b0,
        BANK_READY = 1'b1
    } bank_state_e;

endpackage

// File: rtl/campix_qualify.sv
// Camera-domain front end. It qualifies pixels on all three strobes and
// holds one pixel back, so that the line end (the fall of the line
// strobe) can be tagged on the last pixel. It also tags the first pixel of
// a frame and counts lines per frame.
// Assumes: the line strobe falls before the frame strobe falls, and a
// push is dropped when the FIFO reports full.
module campix_qualify #(
    parameter int PIX_W     = campix_pkg::DEF_PIX_W,
    parameter int MAX_LINES = campix_pkg::DEF_MAX_LINES,
    localparam int EW       = PIX_W + 2,
    localparam int LCNT_W   = $clog2(MAX_LINES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fval,
    input  logic             lval,
    input  logic             dval,
    input  logic [PIX_W-1:0] pix,
    input  logic             fifo_full,
    output logic             push,
    output logic [EW-1:0]    push_data,
    output logic             line_err
);

    logic              fval_q, lval_q;
    logic              sof_arm;
    logic              pend_v, pend_sof;
    logic [PIX_W-1:0]  pend_pix;
    logic [LCNT_W-1:0] line_cnt;
    logic              accept, lval_fall, fval_rise, lval_rise;

    // Strobe qualification and edge detection.
    always_comb begin
        accept    = fval & lval & dval;
        lval_fall = lval_q & ~lval;
        lval_rise = lval & ~lval_q;
        fval_rise = fval & ~fval_q;
    end

    // The held pixel leaves when a newer pixel arrives or when the line ends.
    always_comb begin
        push      = pend_v & (accept | lval_fall) & ~fifo_full;
        push_data = {pend_sof, lval_fall, pend_pix};
    end

    // Edge history, start-of-frame arming and the held pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fval_q   <= 1'b0;
            lval_q   <= 1'b0;
            sof_arm  <= 1'b0;
            pend_v   <= 1'b0;
            pend_sof <= 1'b0;
            pend_pix <= '0;
        end else begin
            fval_q <= fval;
            lval_q <= lval;
            if (accept) begin
                pend_v   <= 1'b1;
                pend_sof <= sof_arm | fval_rise;
                pend_pix <= pix;
                sof_arm  <= 1'b0;
            end else begin
                if (fval_rise) sof_arm <= 1'b1;
                if (lval_fall) pend_v  <= 1'b0;
            end
        end
    end

    // Per-frame line counter and the sticky too-many-lines flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
            line_err <= 1'b0;
        end else if (!fval) begin
            line_cnt <= '0;
        end else if (lval_rise) begin
            if (line_cnt == LCNT_W'(MAX_LINES)) line_err <= 1'b1;
            else                                line_cnt <= line_cnt + 1'b1;
        end
    end

    AST_LINE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt <= LCNT_W'(MAX_LINES)); // R8
    AST_LINE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |=> line_err); // R8
    AST_CNT_CLEARED_OUT_OF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !fval |=> line_cnt == '0); // R8

endmodule

// File: rtl/campix_afifo.sv
// Dual-clock FIFO with binary counters for addressing and Gray copies for
// the crossing. Each Gray copy is synchronised by two flops into the other
// domain. The full and empty flags are computed from the Gray copies.
// Assumes: AW >= 2 and a write is ignored while full.
module campix_afifo #(
    parameter int W  = 14,
    parameter int AW = campix_pkg::DEF_FIFO_AW,
    localparam int DEPTH = 1 << AW
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wen,
    input  logic [W-1:0] wdata,
    output logic         wfull,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         ren,
    output logic [W-1:0] rdata,
    output logic         rempty
);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin, wgray, rbin, rgray;
    logic [AW:0]  rgray_w1, rgray_w2, wgray_r1, wgray_r2;
    logic [AW:0]  wbin_nxt, rbin_nxt;

    // Next binary pointer values.
    always_comb begin
        wbin_nxt = wbin + 1'b1;
        rbin_nxt = rbin + 1'b1;
    end

    // Write side: storage, pointer advance and the Gray copy.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wen && !wfull) begin
            mem[wbin[AW-1:0]] <= wdata;
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Read side: pointer advance and the Gray copy.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (ren && !rempty) begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    // Bring the read pointer into the write domain.
    always_ff @(posedge wclk) begin
        if (!wrst_n) {rgray_w2, rgray_w1} <= '0;
        else         {rgray_w2, rgray_w1} <= {rgray_w1, rgray};
    end

    // Bring the write pointer into the read domain.
    always_ff @(posedge rclk) begin
        if (!rrst_n) {wgray_r2, wgray_r1} <= '0;
        else         {wgray_r2, wgray_r1} <= {wgray_r1, wgray};
    end

    // Full: the top two Gray bits differ and the rest match. Empty: all match.
    always_comb begin
        wfull  = (wgray == {~rgray_w2[AW:AW-1], rgray_w2[AW-2:0]});
        rempty = (rgray == wgray_r2);
        rdata  = mem[rbin[AW-1:0]];
    end

    AST_FIFO_WPTR_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wbin == $past(wbin)) || (wbin == $past(wbin) + 1'b1)); // R3
    AST_FIFO_RPTR_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rbin == $past(rbin)) || (rbin == $past(rbin) + 1'b1)); // R3
    AST_FIFO_GRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (!rrst_n)
        $countones(rgray ^ $past(rgray)) <= 1); // R3

endmodule

// File: rtl/campix_banks.sv
// System-domain ping-pong stage. It pops FIFO entries and writes them into
// one of two line banks. A bank closes on a line end or when it is full.
// The reader drains closed banks in order toward the USB-side write port.
// A line that starts on a bank that has not been drained is dropped whole.
// Assumes: an entry is {sof, line_end, pixel}, valid while in_valid is high.
module campix_banks #(
    parameter int PIX_W    = campix_pkg::DEF_PIX_W,
    parameter int OUT_W    = campix_pkg::DEF_OUT_W,
    parameter int LINE_PIX = campix_pkg::DEF_LINE_PIX,
    localparam int EW      = PIX_W + 2,
    localparam int CNT_W   = $clog2(LINE_PIX + 1),
    localparam int IDX_W   = $clog2(LINE_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [EW-1:0]    in_data,
    input  logic             usb_full,
    output logic             usb_wr,
    output logic [OUT_W-1:0] usb_data,
    output logic             usb_sof,
    output logic             usb_eol,
    output logic             ovf_flag
);
    import campix_pkg::*;

    bank_state_e       bank_st  [2];
    logic [CNT_W-1:0]  bank_len [2];
    logic [EW-1:0]     bank_q   [2];
    logic              wr_bank, rd_bank, dropping;
    logic [CNT_W-1:0]  wr_cnt, rd_idx;
    logic              in_sof, in_lend, drop_now, store, close_line;
    logic              rd_go, rd_last;
    logic [EW-1:0]     wr_word, rd_word;
    logic [1:0]        set_ready, set_free;

    // Writer decisions for the entry at the FIFO head.
    always_comb begin
        in_sof     = in_data[EW-1];
        in_lend    = in_data[EW-2];
        drop_now   = in_valid & (dropping |
                     ((wr_cnt == '0) & (bank_st[wr_bank] == BANK_READY)));
        store      = in_valid & ~drop_now;
        close_line = in_valid & (in_lend | (wr_cnt == CNT_W'(LINE_PIX - 1)));
        wr_word    = {in_sof, close_line, in_data[PIX_W-1:0]};
    end

    // The two bank memories, one generated block per bank.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [EW-1:0] mem [LINE_PIX];
        // Store the entry into this bank when it is the write target.
        always_ff @(posedge clk) begin
            if (store && (wr_bank == 1'(b))) mem[wr_cnt[IDX_W-1:0]] <= wr_word;
        end
        assign bank_q[b]    = mem[rd_idx[IDX_W-1:0]];
        assign set_ready[b] = store & close_line & (wr_bank == 1'(b));
        assign set_free[b]  = rd_go & rd_last & (rd_bank == 1'(b));
    end

    // Reader decisions for the bank being drained.
    always_comb begin
        rd_word = bank_q[rd_bank];
        rd_go   = (bank_st[rd_bank] == BANK_READY) & ~usb_full;
        rd_last = (rd_idx == bank_len[rd_bank] - 1'b1);
    end

    // Bank state: the writer marks a bank ready and the reader frees it.
    always_ff @(posedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (!rst_n)            bank_st[b] <= BANK_FREE;
            else if (set_ready[b]) bank_st[b] <= BANK_READY;
            else if (set_free[b])  bank_st[b] <= BANK_FREE;
        end
    end

    // Writer position, drop mode, bank lengths and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank     <= 1'b0;
            wr_cnt      <= '0;
            dropping    <= 1'b0;
            ovf_flag    <= 1'b0;
            bank_len[0] <= '0;
            bank_len[1] <= '0;
        end else if (in_valid) begin
            if (drop_now) ovf_flag <= 1'b1;
            if (close_line) begin
                wr_cnt   <= '0;
                dropping <= 1'b0;
                if (store) begin
                    bank_len[wr_bank] <= wr_cnt + 1'b1;
                    wr_bank           <= ~wr_bank;
                end
            end else begin
                wr_cnt   <= wr_cnt + 1'b1;
                dropping <= drop_now;
            end
        end
    end

    // Reader position and the registered USB-side write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bank  <= 1'b0;
            rd_idx   <= '0;
            usb_wr   <= 1'b0;
            usb_data <= '0;
            usb_sof  <= 1'b0;
            usb_eol  <= 1'b0;
        end else begin
            usb_wr  <= rd_go;
            usb_sof <= rd_go & rd_word[EW-1];
            usb_eol <= rd_go & rd_word[EW-2];
            if (rd_go) begin
                usb_data <= OUT_W'(rd_word[PIX_W-1:0]);
                if (rd_last) begin
                    rd_idx  <= '0;
                    rd_bank <= ~rd_bank;
                end else begin
                    rd_idx <= rd_idx + 1'b1;
                end
            end
        end
    end

    AST_USB_WR_AFTER_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        usb_wr |-> !$past(usb_full)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R6
    AST_MARK_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_sof || usb_eol) |-> usb_wr); // R7
    AST_BANK_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_len[0] <= CNT_W'(LINE_PIX)) && (bank_len[1] <= CNT_W'(LINE_PIX))); // R4
    AST_WRITER_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt < CNT_W'(LINE_PIX)); // R4

endmodule

// File: rtl/campix_pingpong.sv
// Top level of the camera capture block. Camera-domain qualification feeds
// a dual-clock FIFO, and the system-domain ping-pong banks drain it toward
// a USB-side slave FIFO write port.
// Assumes: sys_clk runs at least as fast as cam_clk, and each domain has
// its own synchronous active-low reset.
module campix_pingpong #(
    parameter int PIX_W     = campix_pkg::DEF_PIX_W,
    parameter int OUT_W     = campix_pkg::DEF_OUT_W,
    parameter int LINE_PIX  = campix_pkg::DEF_LINE_PIX,
    parameter int MAX_LINES = campix_pkg::DEF_MAX_LINES,
    parameter int FIFO_AW   = campix_pkg::DEF_FIFO_AW,
    localparam int EW       = PIX_W + 2
) (
    input  logic             cam_clk,
    input  logic             cam_rst_n,
    input  logic             cam_fval,
    input  logic             cam_lval,
    input  logic             cam_dval,
    input  logic [PIX_W-1:0] cam_data,
    output logic             line_err,
    input  logic             sys_clk,
    input  logic             sys_rst_n,
    input  logic             usb_full,
    output logic             usb_wr,
    output logic [OUT_W-1:0] usb_data,
    output logic             usb_sof,
    output logic             usb_eol,
    output logic             ovf_flag
);

    logic          push, fifo_full, fifo_empty;
    logic [EW-1:0] push_data, pop_data;

    campix_qualify #(
        .PIX_W     (PIX_W),
        .MAX_LINES (MAX_LINES)
    ) u_qualify (
        .clk       (cam_clk),
        .rst_n     (cam_rst_n),
        .fval      (cam_fval),
        .lval      (cam_lval),
        .dval      (cam_dval),
        .pix       (cam_data),
        .fifo_full (fifo_full),
        .push      (push),
        .push_data (push_data),
        .line_err  (line_err)
    );

    campix_afifo #(
        .W  (EW),
        .AW (FIFO_AW)
    ) u_afifo (
        .wclk   (cam_clk),
        .wrst_n (cam_rst_n),
        .wen    (push),
        .wdata  (push_data),
        .wfull  (fifo_full),
        .rclk   (sys_clk),
        .rrst_n (sys_rst_n),
        .ren    (!fifo_empty),
        .rdata  (pop_data),
        .rempty (fifo_empty)
    );

    campix_banks #(
        .PIX_W    (PIX_W),
        .OUT_W    (OUT_W),
        .LINE_PIX (LINE_PIX)
    ) u_banks (
        .clk      (sys_clk),
        .rst_n    (sys_rst_n),
        .in_valid (!fifo_empty),
        .in_data  (pop_data),
        .usb_full (usb_full),
        .usb_wr   (usb_wr),
        .usb_data (usb_data),
        .usb_sof  (usb_sof),
        .usb_eol  (usb_eol),
        .ovf_flag (ovf_flag)
    );

endmodule

// File: tb/campix_pingpong_bench.sv
// Bench: seeded random lines and directed corner cases. Expected words are
// built from the requirements into a queue and compared at the port.
module campix_pingpong_bench;

    logic        cam_clk = 1'b0, sys_clk = 1'b0;
    logic        cam_rst_n = 1'b0, sys_rst_n = 1'b0;
    logic        cam_fval = 1'b0, cam_lval = 1'b0, cam_dval = 1'b0;
    logic [11:0] cam_data = '0;
    logic        usb_full = 1'b0;
    logic        line_err, usb_wr, usb_sof, usb_eol, ovf_flag;
    logic [15:0] usb_data;

    int checks = 0;
    int errors = 0;
    int full_mode = 0;
    logic [17:0] exp_q [$];

    always #5 cam_clk = ~cam_clk;
    always #4 sys_clk = ~sys_clk;

    campix_pingpong u_campix_pingpong (
        .cam_clk   (cam_clk),
        .cam_rst_n (cam_rst_n),
        .cam_fval  (cam_fval),
        .cam_lval  (cam_lval),
        .cam_dval  (cam_dval),
        .cam_data  (cam_data),
        .line_err  (line_err),
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .usb_full  (usb_full),
        .usb_wr    (usb_wr),
        .usb_data  (usb_data),
        .usb_sof   (usb_sof),
        .usb_eol   (usb_eol),
        .ovf_flag  (ovf_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] exp_word(input bit sof, input bit eol, input logic [11:0] p);
        return {sof, eol, 4'b0000, p};
    endfunction

    // Back-pressure driver: 0 = room, 1 = full, 2 = random 25 % full.
    always @(negedge sys_clk) begin
        if (full_mode == 0)      usb_full = 1'b0;
        else if (full_mode == 1) usb_full = 1'b1;
        else                     usb_full = (($urandom % 4) == 0);
    end

    // Output monitor: every word must match the head of the expected queue.
    always @(negedge sys_clk) begin
        if (sys_rst_n && usb_wr) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected word", int'(usb_data), 0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                check(usb_data == e[15:0], "R2 data", int'(usb_data), int'(e[15:0]));
                check({usb_sof, usb_eol} == e[17:16], "R7 markers",
                      int'({usb_sof, usb_eol}), int'(e[17:16]));
            end
        end
    end

    task automatic cam_cycle(input bit f, input bit l, input bit d, input logic [11:0] p);
        @(negedge cam_clk);
        cam_fval = f; cam_lval = l; cam_dval = d; cam_data = p;
    endtask

    task automatic frame_begin();
        cam_cycle(1'b0, 1'b1, 1'b1, 12'(($urandom)));   // junk outside frame, R1
        cam_cycle(1'b0, 1'b0, 1'b1, 12'(($urandom)));
        cam_cycle(1'b1, 1'b0, 1'b1, 12'(($urandom)));   // junk between lines, R1
    endtask

    task automatic frame_end();
        cam_cycle(1'b1, 1'b0, 1'b0, '0);
        cam_cycle(1'b0, 1'b0, 1'b0, '0);
        cam_cycle(1'b0, 1'b0, 1'b0, '0);
    endtask

    // One line of len pixels, with dval gaps at gap_pct percent.
    task automatic send_line(input int len, input bit first, input bit record,
                             input int gap_pct, input int idle);
        for (int i = 0; i < len; i++) begin
            logic [11:0] p;
            while (($urandom % 100) < gap_pct)
                cam_cycle(1'b1, 1'b1, 1'b0, 12'(($urandom)));  // R1 dval low
            p = 12'(($urandom));
            cam_cycle(1'b1, 1'b1, 1'b1, p);
            if (record)
                exp_q.push_back(exp_word(first && i == 0,
                                         ((i % 1024) == 1023) || (i == len - 1), p));
        end
        for (int k = 0; k < idle; k++)
            cam_cycle(1'b1, 1'b0, 1'($urandom), 12'(($urandom)));
    endtask

    task automatic wait_drain();
        repeat (400) @(posedge sys_clk);
        @(negedge sys_clk);
        check(exp_q.size() == 0, "R2 all words delivered", exp_q.size(), 0);
    endtask

    task automatic do_reset();
        cam_rst_n = 1'b0; sys_rst_n = 1'b0;
        repeat (6) @(posedge cam_clk);
        @(negedge sys_clk);
        check(usb_wr == 1'b0, "R10 usb_wr in reset", usb_wr, 0);
        check(ovf_flag == 1'b0, "R10 ovf_flag in reset", ovf_flag, 0);
        @(negedge cam_clk);
        check(line_err == 1'b0, "R10 line_err in reset", line_err, 0);
        cam_rst_n = 1'b1; sys_rst_n = 1'b1;
        repeat (4) @(posedge cam_clk);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0C4A);
        do_reset();

        // Random lines under random back-pressure: R1 R2 R3 R5 R9.
        full_mode = 2;
        for (int f = 0; f < 3; f++) begin
            frame_begin();
            for (int l = 0; l < 8; l++) begin
                int len;
                len = 1 + int'($urandom % 48);
                send_line(len, l == 0, 1'b1, 30, 2 * len + 40);
            end
            frame_end();
        end
        wait_drain();
        check(ovf_flag == 1'b0, "R6 no false overflow", ovf_flag, 0);

        // Long lines: R4 split at 1024, exactly 1024, R5 partial close.
        full_mode = 0;
        frame_begin();
        send_line(1030, 1'b1, 1'b1, 0, 2200);
        send_line(1024, 1'b0, 1'b1, 5, 2200);
        send_line(3, 1'b0, 1'b1, 0, 20);
        frame_end();
        wait_drain();

        // Overflow: both banks held, third line dropped whole: R6 R9.
        full_mode = 1;
        frame_begin();
        send_line(20, 1'b1, 1'b1, 10, 10);
        send_line(15, 1'b0, 1'b1, 10, 10);
        send_line(12, 1'b0, 1'b0, 10, 10);
        repeat (100) @(posedge sys_clk);
        @(negedge sys_clk);
        check(exp_q.size() == 35, "R9 stalled while full", exp_q.size(), 35);
        check(ovf_flag == 1'b1, "R6 overflow flagged", ovf_flag, 1);
        full_mode = 0;
        repeat (200) @(posedge sys_clk);
        send_line(10, 1'b0, 1'b1, 0, 10);
        frame_end();
        wait_drain();
        check(ovf_flag == 1'b1, "R6 overflow sticky", ovf_flag, 1);
        do_reset();

        // Line counting: two frames of 1024 lines, then one of 1025: R8.
        for (int f = 0; f < 3; f++) begin
            int nl;
            nl = (f == 2) ? 1025 : 1024;
            frame_begin();
            for (int l = 0; l < nl; l++) send_line(1, l == 0, 1'b1, 0, 2);
            frame_end();
            @(negedge cam_clk);
            check(line_err == (f == 2), "R8 line_err after frame", line_err, int'(f == 2));
        end
        wait_drain();
        check(ovf_flag == 1'b0, "R6 no overflow on short lines", ovf_flag, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge sys_clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, queue=%0d expected=0", exp_q.size());
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule